// File: doc/BRIEF.md
# Circular Multi-Row Image Line Cache

This block keeps a few rows of a convolution layer's input feature map on chip. Values are stored by row, then column, then channel, so all channels of one pixel sit at consecutive addresses. A layer configuration sets the image width, the height and the number of input channels. A write stream then fills the store one channel value per cycle. The write pointer runs around a ring of `NUM_LINES` rows, so each new pixel replaces the oldest one in its slot.

A read port takes a signed row, a signed column and a channel index. It returns the stored value one cycle later. When the coordinate falls outside the image it returns zero instead, which acts as implicit zero padding for the convolution window.

A down-counter tracks how many values of the layer are still to be loaded. Writes are ignored once it reaches zero. A typical sequence fills row 0 completely, then one pixel of row 1. After that it adds one pixel of `ch` values per output-pixel step.

Top module: `img_line_cache`

## Requirements
- R1: After reset `loads_left_o` is 0, `rd_valid_o` is 0 and `rd_data_o` is 0. Write values offered before any configuration are not stored.
- R2: When `cfg_valid_i` is high:
  - the geometry is taken from the inputs;
  - the write pointer returns to slot 0;
  - `loads_left_o` becomes width × height × channels;
  - a write offered in that same cycle is discarded.
- R3: Each accepted write stores at the current pointer, then advances the pointer by one. After slot NUM_LINES × channels × width − 1 the pointer goes back to 0.
- R4: A read of (y, x, ci) inside the image returns the entry at (y mod NUM_LINES) × channels × width + x × channels + ci. This is the row/column/channel layout with channel fastest.
- R5: A read with x < 0, x ≥ width, y < 0 or y ≥ height returns 0.
- R6: `loads_left_o` drops by the channel count on the write that completes a pixel. The last channel of a pixel is channel index channels − 1. `loads_left_o` is unchanged on the other writes.
- R7: While `loads_left_o` is 0, a write neither changes stored data nor moves the pointer.
- R8: A read issued in cycle n gives `rd_valid_o` high and its data in cycle n+1. Without a read, `rd_valid_o` is low and `rd_data_o` keeps its last value.
- R9: A read and a write to the same slot in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Load layer geometry and restart the fill |
| cfg_width_i | input | WDIM_W | Image width in pixels |
| cfg_height_i | input | HDIM_W | Image height in rows |
| cfg_chans_i | input | CDIM_W | Input channels per pixel |
| wr_valid_i | input | 1 | Offer one channel value for storing |
| wr_data_i | input | DATA_W | Channel value to store |
| rd_valid_i | input | 1 | Read request |
| rd_y_i | input | COORD_W | Signed row coordinate |
| rd_x_i | input | COORD_W | Signed column coordinate |
| rd_ci_i | input | CDIM_W | Channel index |
| rd_valid_o | output | 1 | Read result valid (one cycle after the request) |
| rd_data_o | output | DATA_W | Read result, zero for padding coordinates |
| loads_left_o | output | LOADS_W | Values still to be loaded in this layer |

## Verification
The write port and the read port can both address the same ring slot in the same cycle. This happens at the start of a refill, when the first new value of a layer lands in a slot still holding the previous layer's data. The bench provokes this with a reconfiguration, then a cycle that writes slot 0 while reading coordinate (0,0,0). It expects the old content back, and the new value on the following read. The configuration also coincides with a write in one cycle; that write must leave both the counter and slot 0 untouched.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LC_GEOM_W = 16;

  typedef struct packed {
    logic [LC_GEOM_W-1:0] width;
    logic [LC_GEOM_W-1:0] height;
    logic [LC_GEOM_W-1:0] chans;
    logic [LC_GEOM_W-1:0] line_len;
    logic [LC_GEOM_W-1:0] ring_last;
  } lc_geom_t;
endpackage

// File: rtl/lc_wr_ctrl.sv
module lc_wr_ctrl
  import lc_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int WDIM_W    = 5,
  parameter int HDIM_W    = 5,
  parameter int CDIM_W    = 4,
  parameter int ADDR_W    = 9,
  parameter int LOADS_W   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_valid_i,
  input  logic [WDIM_W-1:0]  cfg_width_i,
  input  logic [HDIM_W-1:0]  cfg_height_i,
  input  logic [CDIM_W-1:0]  cfg_chans_i,
  input  logic               wr_valid_i,
  output lc_geom_t           geom_o,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [LOADS_W-1:0] loads_left_o
);
  lc_geom_t           geom_q;
  logic [ADDR_W-1:0]  wr_addr_q;
  logic [CDIM_W-1:0]  chan_cnt_q;
  logic [LOADS_W-1:0] loads_left_q;
  logic [31:0]        cfg_line;
  logic               wr_en;
  logic               pixel_done;

  assign cfg_line   = 32'(cfg_chans_i) * 32'(cfg_width_i);
  assign wr_en      = wr_valid_i && !cfg_valid_i && (loads_left_q != '0);
  assign pixel_done = (LC_GEOM_W'(chan_cnt_q) == geom_q.chans - LC_GEOM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      geom_q       <= '0;
      wr_addr_q    <= '0;
      chan_cnt_q   <= '0;
      loads_left_q <= '0;
    end else if (cfg_valid_i) begin
      geom_q.width     <= LC_GEOM_W'(cfg_width_i);
      geom_q.height    <= LC_GEOM_W'(cfg_height_i);
      geom_q.chans     <= LC_GEOM_W'(cfg_chans_i);
      geom_q.line_len  <= LC_GEOM_W'(cfg_line);
      geom_q.ring_last <= LC_GEOM_W'(cfg_line * 32'(NUM_LINES) - 32'd1);
      loads_left_q     <= LOADS_W'(cfg_line * 32'(cfg_height_i));
      wr_addr_q        <= '0;
      chan_cnt_q       <= '0;
    end else if (wr_en) begin
      if (LC_GEOM_W'(wr_addr_q) == geom_q.ring_last) wr_addr_q <= '0;
      else wr_addr_q <= wr_addr_q + ADDR_W'(1);
      if (pixel_done) begin
        chan_cnt_q   <= '0;
        loads_left_q <= loads_left_q - LOADS_W'(geom_q.chans);
      end else begin
        chan_cnt_q <= chan_cnt_q + CDIM_W'(1);
      end
    end
  end

  assign geom_o       = geom_q;
  assign wr_en_o      = wr_en;
  assign wr_addr_o    = wr_addr_q;
  assign loads_left_o = loads_left_q;

  AST_RING_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && LC_GEOM_W'(wr_addr_q) == geom_q.ring_last) |=> (wr_addr_q == '0)); // R3
  AST_LOADS_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_i |=> (loads_left_q <= $past(loads_left_q))); // R6
  AST_IDLE_WHEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loads_left_q == '0 && !cfg_valid_i) |=> $stable(wr_addr_q)); // R7
endmodule

// File: rtl/lc_addr_gen.sv
module lc_addr_gen
  import lc_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int COORD_W   = 8,
  parameter int CDIM_W    = 4,
  parameter int ADDR_W    = 9
) (
  input  lc_geom_t                   geom_i,
  input  logic signed [COORD_W-1:0]  y_i,
  input  logic signed [COORD_W-1:0]  x_i,
  input  logic        [CDIM_W-1:0]   ci_i,
  output logic        [ADDR_W-1:0]   addr_o,
  output logic                       pad_o
);
  localparam bit LINES_POW2 = (NUM_LINES & (NUM_LINES - 1)) == 0;
  localparam int LINE_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [31:0] row_slot;
  logic [31:0] x_u;
  logic [31:0] y_u;
  logic [31:0] addr_full;
  logic        x_out;
  logic        y_out;

  assign x_u = 32'($unsigned(x_i));
  assign y_u = 32'($unsigned(y_i));

  generate
    if (LINES_POW2) begin : g_slice
      assign row_slot = 32'(y_u[LINE_W-1:0]);
    end else begin : g_modulo
      assign row_slot = y_u % 32'(NUM_LINES);
    end
  endgenerate

  assign addr_full = row_slot * 32'(geom_i.line_len) + x_u * 32'(geom_i.chans) + 32'(ci_i);
  assign addr_o    = ADDR_W'(addr_full);

  // Padding border: negative or beyond the configured extent
  assign x_out = x_i[COORD_W-1] || (x_u >= 32'(geom_i.width));
  assign y_out = y_i[COORD_W-1] || (y_u >= 32'(geom_i.height));
  assign pad_o = x_out || y_out;
endmodule

// File: rtl/lc_store.sv
module lc_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_pad_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              pad_q;
  logic              valid_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i && (32'(wr_addr_i) < DEPTH)) mem[wr_addr_i] <= wr_data_i;
  end

  // Registered read sees the pre-write content on a same-slot collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      pad_q   <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en_i;
      if (rd_en_i) begin
        pad_q <= rd_pad_i;
        rd_q  <= (32'(rd_addr_i) < DEPTH) ? mem[rd_addr_i] : '0;
      end
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = pad_q ? '0 : rd_q;
endmodule

// File: rtl/img_line_cache.sv
module img_line_cache
  import lc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_LINES = 4,
  parameter int MAX_W     = 16,
  parameter int MAX_H     = 16,
  parameter int MAX_CH    = 8,
  parameter int COORD_W   = 8,
  localparam int WDIM_W   = $clog2(MAX_W + 1),
  localparam int HDIM_W   = $clog2(MAX_H + 1),
  localparam int CDIM_W   = $clog2(MAX_CH + 1),
  localparam int LOADS_W  = $clog2(MAX_W * MAX_H * MAX_CH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_valid_i,
  input  logic [WDIM_W-1:0]         cfg_width_i,
  input  logic [HDIM_W-1:0]         cfg_height_i,
  input  logic [CDIM_W-1:0]         cfg_chans_i,
  input  logic                      wr_valid_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic                      rd_valid_i,
  input  logic signed [COORD_W-1:0] rd_y_i,
  input  logic signed [COORD_W-1:0] rd_x_i,
  input  logic [CDIM_W-1:0]         rd_ci_i,
  output logic                      rd_valid_o,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic [LOADS_W-1:0]        loads_left_o
);
  localparam int DEPTH  = NUM_LINES * MAX_W * MAX_CH;
  localparam int ADDR_W = $clog2(DEPTH);

  lc_geom_t          geom;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_pad;

  lc_wr_ctrl #(
    .NUM_LINES(NUM_LINES), .WDIM_W(WDIM_W), .HDIM_W(HDIM_W),
    .CDIM_W(CDIM_W), .ADDR_W(ADDR_W), .LOADS_W(LOADS_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_valid_i  (cfg_valid_i),
    .cfg_width_i  (cfg_width_i),
    .cfg_height_i (cfg_height_i),
    .cfg_chans_i  (cfg_chans_i),
    .wr_valid_i   (wr_valid_i),
    .geom_o       (geom),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .loads_left_o (loads_left_o)
  );

  lc_addr_gen #(
    .NUM_LINES(NUM_LINES), .COORD_W(COORD_W), .CDIM_W(CDIM_W), .ADDR_W(ADDR_W)
  ) u_agen (
    .geom_i (geom),
    .y_i    (rd_y_i),
    .x_i    (rd_x_i),
    .ci_i   (rd_ci_i),
    .addr_o (rd_addr),
    .pad_o  (rd_pad)
  );

  lc_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_valid_i),
    .rd_addr_i  (rd_addr),
    .rd_pad_i   (rd_pad),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_valid_o); // R8
  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> (!rd_valid_o && $stable(rd_data_o))); // R8
  AST_PAD_NEG_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_y_i < 0) |=> (rd_data_o == '0)); // R5
  AST_PAD_NEG_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_x_i < 0) |=> (rd_data_o == '0)); // R5
endmodule

// File: tb/sim_img_line_cache.sv
module sim_img_line_cache;
  localparam int DATA_W = 16;
  localparam int NENT   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_valid = 1'b0;
  logic [4:0]        cfg_width = '0;
  logic [4:0]        cfg_height = '0;
  logic [3:0]        cfg_chans = '0;
  logic              wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_valid = 1'b0;
  logic signed [7:0] rd_y = '0;
  logic signed [7:0] rd_x = '0;
  logic [3:0]        rd_ci = '0;
  logic              rd_valid_o;
  logic [DATA_W-1:0] rd_data_o;
  logic [11:0]       loads_left_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  img_line_cache u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_valid_i(cfg_valid), .cfg_width_i(cfg_width),
    .cfg_height_i(cfg_height), .cfg_chans_i(cfg_chans),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_valid_i(rd_valid), .rd_y_i(rd_y), .rd_x_i(rd_x), .rd_ci_i(rd_ci),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .loads_left_o(loads_left_o)
  );

  // {y, x, ci, expected} after row 0 and one pixel of row 1 (W3 H5 C2, value k = 0x100+k)
  localparam logic [35:0] TBL [NENT] = '{
    {8'sd0,  8'sd0,  4'd0, 16'h0100},
    {8'sd0,  8'sd2,  4'd1, 16'h0105},
    {8'sd1,  8'sd0,  4'd1, 16'h0107},
    {8'sd0,  8'sd1,  4'd0, 16'h0102},
    {-8'sd1, 8'sd0,  4'd0, 16'h0000},
    {8'sd0,  -8'sd1, 4'd0, 16'h0000},
    {8'sd0,  8'sd3,  4'd0, 16'h0000},
    {8'sd5,  8'sd0,  4'd0, 16'h0000}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic configure(input int w, input int h, input int c,
                           input bit with_wr, input logic [DATA_W-1:0] d);
    cfg_valid = 1'b1; cfg_width = 5'(w); cfg_height = 5'(h); cfg_chans = 4'(c);
    wr_valid = with_wr; wr_data = d;
    @(negedge clk);
    cfg_valid = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic write_one(input logic [DATA_W-1:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic read_chk(input int y, input int x, input int ci,
                          input logic [DATA_W-1:0] exp, input string req);
    rd_valid = 1'b1; rd_y = 8'(y); rd_x = 8'(x); rd_ci = 4'(ci);
    @(negedge clk);
    rd_valid = 1'b0;
    check(32'(rd_valid_o), 32'd1, "R8 valid");
    check(32'(rd_data_o), 32'(exp), req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(32'(loads_left_o), 32'd0, "R1 loads_left");
    check(32'(rd_valid_o), 32'd0, "R1 rd_valid");
    check(32'(rd_data_o), 32'd0, "R1 rd_data");
    rst_n = 1'b1;
    @(negedge clk);
    write_one(16'h5555);
    check(32'(loads_left_o), 32'd0, "R1 unconfigured write ignored");

    // R2 config with colliding write
    configure(3, 5, 2, 1'b1, 16'h3333);
    check(32'(loads_left_o), 32'd30, "R2 load count");

    // R6 count per pixel
    write_one(16'h0100);
    check(32'(loads_left_o), 32'd30, "R6 mid-pixel");
    write_one(16'h0101);
    check(32'(loads_left_o), 32'd28, "R6 pixel done");
    for (int k = 2; k < 8; k++) write_one(16'(16'h0100 + k));
    check(32'(loads_left_o), 32'd22, "R6 row0 plus one pixel");

    // R4 / R5 table
    for (int i = 0; i < NENT; i++) begin
      logic [35:0] e;
      e = TBL[i];
      read_chk($signed(e[35:28]), $signed(e[27:20]), int'(e[19:16]), e[15:0],
               (e[15:0] == 16'h0) ? "R5 padding" : "R4 layout");
    end
    // R8 hold
    @(negedge clk);
    check(32'(rd_valid_o), 32'd0, "R8 idle valid");
    check(32'(rd_data_o), 32'd0, "R8 idle hold");

    // R3 wrap
    for (int k = 8; k < 30; k++) write_one(16'(16'h0100 + k));
    check(32'(loads_left_o), 32'd0, "R6 all loaded");
    read_chk(4, 0, 0, 16'h0118, "R3 wrapped row");
    read_chk(4, 2, 1, 16'h011D, "R3 wrapped row end");
    read_chk(1, 0, 0, 16'h0106, "R3 row1 kept");

    // R7 suppression
    write_one(16'hBEEF);
    check(32'(loads_left_o), 32'd0, "R7 counter");
    read_chk(1, 0, 0, 16'h0106, "R7 no store");

    // R9 collision after reconfig (R2 colliding write discarded)
    configure(3, 5, 2, 1'b1, 16'h3333);
    check(32'(loads_left_o), 32'd30, "R2 reload");
    wr_valid = 1'b1; wr_data = 16'h2222;
    rd_valid = 1'b1; rd_y = 8'sd0; rd_x = 8'sd0; rd_ci = 4'd0;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    check(32'(rd_data_o), 32'h0118, "R9 old value");
    read_chk(0, 0, 0, 16'h2222, "R3 restart at slot 0");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule